// File: doc/BRIEF.md
# Transmit PHY power-up and clock-lane sequencer

This block brings a serial display transmit PHY out of power-down in a fixed order. It then controls when the PHY's clock lane runs in high-speed mode. A start pulse begins the sequence. During a hold phase the clock-enable, shutdown and reset controls of the PHY are all held low. They are then released one at a time. The PHY's analog side is represented by handshake inputs: a PLL lock indication, a clock-lane stop indication and one stop indication per data lane. The sequencer waits for lock and then for stop state on the clock lane and on the first data lane before it reports ready. If either wait runs past a programmable limit, the block latches a fault and parks the PHY controls low.

After the PHY is ready, the clock lane runs in one of two modes. In manual mode the high-speed clock request follows a request input. In automatic mode the clock lane is kept in low power between transmissions. A transmit request first starts the clock lane and then the data lanes, each after its own programmed lead time, and only then lets data go. When the request ends, the data lanes get a programmed tail time. The block then waits until every enabled data lane is back in stop state, and after the clock-lane tail time it drops the clock lane to low power.

Top module: `phy_link_seq`

## Requirements
- R1: While reset is applied and right after it, phy_ctrl_o is 0, clk_hs_req_o, tx_go_o, ready_o and fault_o are 0, and status_o is 0 when all PHY inputs are 0.
- R2: A start_i pulse seen while the block is off holds phy_ctrl_o[2:0] at 0 for HOLD_CYC+1 cycles. Clock-enable (phy_ctrl_o[2]) becomes visible HOLD_CYC+1 cycles after the sampling edge. start_i has no effect once the sequence has begun.
- R3: Shutdown release (phy_ctrl_o[0], active low) comes STEP_CYC+1 cycles after clock-enable. Reset release (phy_ctrl_o[1], active low) comes STEP_CYC+1 cycles after that. A later control is never high while an earlier one is low.
- R4: ready_o is set only after phy_lock_i has been seen with reset released, and then clk_stop_i and dat_stop_i[0] have been seen high together. Stop states of lanes 1 to 3 are not needed.
- R5: If lock is not seen within timeout_i+1 cycles of reset release, or stop state is not seen within timeout_i+1 cycles of lock, fault_o is set. It then stays set until reset, ready_o stays 0, phy_ctrl_o[2:0] is 0, and start_i is ignored.
- R6: status_o registers the PHY inputs one cycle late: bit 0 lock, bit 2 clock-lane stop, and data-lane stops of lanes 0, 1, 2, 3 at bits 4, 7, 9, 11. All other bits are 0.
- R7: phy_ctrl_o[3] (force PLL) follows force_pll_i one cycle later.
- R8: In automatic mode (auto_clk_i=1) once ready, a tx_req_i sampled in idle raises clk_hs_req_o one cycle later. tx_go_o rises clk_lp2hs_i+dat_lp2hs_i+2 cycles after that sampling edge. hs_clk_req_i is ignored in this mode.
- R9: In automatic mode, when tx_req_i is sampled low during transmission, tx_go_o falls one cycle later. With the enabled lanes already stopped, clk_hs_req_o falls dat_hs2lp_i+clk_hs2lp_i+3 cycles after that edge.
- R10: lane_cnt_i holds the number of data lanes minus one. The return to low power waits for stop state on lanes 0..lane_cnt_i only. Once they are stopped, clk_hs_req_o falls clk_hs2lp_i+1 cycles later.
- R11: In manual mode (auto_clk_i=0) once ready, clk_hs_req_o equals hs_clk_req_i and tx_go_o equals tx_req_i AND hs_clk_req_i, both one cycle late.
- R12: clk_hs_req_o and tx_go_o stay 0 while ready_o is 0, and tx_go_o is never 1 without clk_hs_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin power-up sequence |
| force_pll_i | input | 1 | Force PLL on request |
| auto_clk_i | input | 1 | 1: automatic clock-lane control |
| hs_clk_req_i | input | 1 | Manual high-speed clock request |
| tx_req_i | input | 1 | Transmission request |
| lane_cnt_i | input | 2 | Active data lanes minus one |
| timeout_i | input | 16 | Lock / stop wait limit in cycles |
| clk_lp2hs_i | input | 10 | Clock-lane LP-to-HS lead time |
| clk_hs2lp_i | input | 10 | Clock-lane HS-to-LP tail time |
| dat_lp2hs_i | input | 8 | Data-lane LP-to-HS lead time |
| dat_hs2lp_i | input | 8 | Data-lane HS-to-LP tail time |
| phy_lock_i | input | 1 | PHY PLL lock |
| clk_stop_i | input | 1 | Clock lane in stop state |
| dat_stop_i | input | 4 | Per-lane data stop state |
| phy_ctrl_o | output | 4 | {force PLL, clock enable, reset_n, shutdown_n} |
| status_o | output | 12 | Registered lock and stop-state view |
| clk_hs_req_o | output | 1 | Clock lane high-speed request |
| tx_go_o | output | 1 | Data may be transmitted |
| ready_o | output | 1 | PHY powered up and qualified |
| fault_o | output | 1 | Sticky wait-timeout fault |

## Verification
Some properties are checked on every cycle. The release order of the three PHY controls must hold. A fault must persist and keep the PHY parked. Ready must be qualified by the stop inputs in the cycle before it rises. No high-speed activity may appear before ready or without a clock request. Exact cycle counts need the bench's scenarios. These cover the hold and step spacing, the timeout distance, the lead and tail times for random timer values including zero, the masking of lanes above the lane count, and the status bit positions.

// File: rtl/phy_seq_pkg.sv
`timescale 1ns/1ps
package phy_seq_pkg;
  typedef enum logic [2:0] {
    PW_OFF, PW_HOLD, PW_ENCLK, PW_SHUT, PW_LOCK, PW_STOP, PW_READY, PW_FAULT
  } pwr_state_e;

  typedef enum logic [2:0] {
    CL_IDLE, CL_CLK_UP, CL_DAT_UP, CL_ACTIVE, CL_DAT_DN, CL_STOP_WAIT, CL_CLK_DN
  } clk_state_e;

  // status bit carrying stop state of data lane i
  function automatic int lane_stat_bit(input int i);
    return (i == 0) ? 4 : 5 + 2 * i;
  endfunction
endpackage

// File: rtl/phy_pwr_fsm.sv
`timescale 1ns/1ps
module phy_pwr_fsm
  import phy_seq_pkg::*;
#(
  parameter int HOLD_CYC = 7,
  parameter int STEP_CYC = 3,
  parameter int TO_W     = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [TO_W-1:0] timeout_i,
  input  logic            lock_i,
  input  logic            clk_stop_i,
  input  logic            dat0_stop_i,
  output logic            en_clk_o,
  output logic            shut_n_o,
  output logic            rst_n_o,
  output logic            ready_o,
  output logic            fault_o
);
  localparam int SEQ_MAX = (HOLD_CYC > STEP_CYC) ? HOLD_CYC : STEP_CYC;
  localparam int SEQ_W   = $clog2(SEQ_MAX + 2);

  pwr_state_e       state_q, state_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic [TO_W-1:0]  to_q, to_d;

  always_comb begin
    state_d = state_q;
    seq_d   = seq_q;
    to_d    = to_q;
    unique case (state_q)
      PW_OFF: if (start_i) begin
        state_d = PW_HOLD;
        seq_d   = SEQ_W'(HOLD_CYC);
      end
      PW_HOLD: if (seq_q == '0) begin
        state_d = PW_ENCLK;
        seq_d   = SEQ_W'(STEP_CYC);
      end else seq_d = seq_q - 1'b1;
      PW_ENCLK: if (seq_q == '0) begin
        state_d = PW_SHUT;
        seq_d   = SEQ_W'(STEP_CYC);
      end else seq_d = seq_q - 1'b1;
      PW_SHUT: if (seq_q == '0) begin
        state_d = PW_LOCK;
        to_d    = '0;
      end else seq_d = seq_q - 1'b1;
      PW_LOCK: if (lock_i) begin
        state_d = PW_STOP;
        to_d    = '0;
      end else if (to_q == timeout_i) state_d = PW_FAULT;
      else to_d = to_q + 1'b1;
      PW_STOP: if (clk_stop_i && dat0_stop_i) state_d = PW_READY;
      else if (to_q == timeout_i) state_d = PW_FAULT;
      else to_d = to_q + 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PW_OFF;
      seq_q   <= '0;
      to_q    <= '0;
    end else begin
      state_q <= state_d;
      seq_q   <= seq_d;
      to_q    <= to_d;
    end
  end

  assign en_clk_o = state_q inside {PW_ENCLK, PW_SHUT, PW_LOCK, PW_STOP, PW_READY};
  assign shut_n_o = state_q inside {PW_SHUT, PW_LOCK, PW_STOP, PW_READY};
  assign rst_n_o  = state_q inside {PW_LOCK, PW_STOP, PW_READY};
  assign ready_o  = (state_q == PW_READY);
  assign fault_o  = (state_q == PW_FAULT);
endmodule

// File: rtl/lane_stop_mask.sv
`timescale 1ns/1ps
module lane_stop_mask #(
  parameter int LANES = 4,
  localparam int LCW  = $clog2(LANES)
) (
  input  logic [LCW-1:0]   lane_cnt_i,
  input  logic [LANES-1:0] stop_i,
  output logic             all_stop_o
);
  logic [LANES-1:0] ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ok[g] = stop_i[g] | (LCW'(g) > lane_cnt_i);
  end

  assign all_stop_o = &ok;
endmodule

// File: rtl/clk_lane_fsm.sv
`timescale 1ns/1ps
module clk_lane_fsm
  import phy_seq_pkg::*;
#(
  parameter int CLK_TW = 10,
  parameter int DAT_TW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic              auto_i,
  input  logic              hs_req_i,
  input  logic              tx_req_i,
  input  logic              lanes_stopped_i,
  input  logic [CLK_TW-1:0] clk_lp2hs_i,
  input  logic [CLK_TW-1:0] clk_hs2lp_i,
  input  logic [DAT_TW-1:0] dat_lp2hs_i,
  input  logic [DAT_TW-1:0] dat_hs2lp_i,
  output logic              clk_hs_req_o,
  output logic              tx_go_o
);
  localparam int TW = (CLK_TW > DAT_TW) ? CLK_TW : DAT_TW;

  clk_state_e    state_q, state_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          hs_q, go_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!(ready_i && auto_i)) begin
      state_d = CL_IDLE;
    end else begin
      unique case (state_q)
        CL_IDLE: if (tx_req_i) begin
          state_d = CL_CLK_UP;
          cnt_d   = TW'(clk_lp2hs_i);
        end
        CL_CLK_UP: if (cnt_q == '0) begin
          state_d = CL_DAT_UP;
          cnt_d   = TW'(dat_lp2hs_i);
        end else cnt_d = cnt_q - 1'b1;
        CL_DAT_UP: if (cnt_q == '0) state_d = CL_ACTIVE;
        else cnt_d = cnt_q - 1'b1;
        CL_ACTIVE: if (!tx_req_i) begin
          state_d = CL_DAT_DN;
          cnt_d   = TW'(dat_hs2lp_i);
        end
        CL_DAT_DN: if (cnt_q == '0) state_d = CL_STOP_WAIT;
        else cnt_d = cnt_q - 1'b1;
        CL_STOP_WAIT: if (lanes_stopped_i) begin
          state_d = CL_CLK_DN;
          cnt_d   = TW'(clk_hs2lp_i);
        end
        CL_CLK_DN: if (cnt_q == '0) state_d = CL_IDLE;
        else cnt_d = cnt_q - 1'b1;
        default: state_d = CL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CL_IDLE;
      cnt_q   <= '0;
      hs_q    <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hs_q    <= ready_i && (auto_i ? (state_d != CL_IDLE) : hs_req_i);
      go_q    <= ready_i && (auto_i ? (state_d == CL_ACTIVE) : (tx_req_i && hs_req_i));
    end
  end

  assign clk_hs_req_o = hs_q;
  assign tx_go_o      = go_q;
endmodule

// File: rtl/phy_link_seq.sv
`timescale 1ns/1ps
module phy_link_seq
  import phy_seq_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int CLK_TW   = 10,
  parameter int DAT_TW   = 8,
  parameter int TO_W     = 16,
  parameter int HOLD_CYC = 7,
  parameter int STEP_CYC = 3,
  localparam int LCW     = $clog2(LANES),
  localparam int STAT_W  = 4 + 2 * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              force_pll_i,
  input  logic              auto_clk_i,
  input  logic              hs_clk_req_i,
  input  logic              tx_req_i,
  input  logic [LCW-1:0]    lane_cnt_i,
  input  logic [TO_W-1:0]   timeout_i,
  input  logic [CLK_TW-1:0] clk_lp2hs_i,
  input  logic [CLK_TW-1:0] clk_hs2lp_i,
  input  logic [DAT_TW-1:0] dat_lp2hs_i,
  input  logic [DAT_TW-1:0] dat_hs2lp_i,
  input  logic              phy_lock_i,
  input  logic              clk_stop_i,
  input  logic [LANES-1:0]  dat_stop_i,
  output logic [3:0]        phy_ctrl_o,
  output logic [STAT_W-1:0] status_o,
  output logic              clk_hs_req_o,
  output logic              tx_go_o,
  output logic              ready_o,
  output logic              fault_o
);
  logic en_clk, shut_n, rst_n, ready, all_stop, force_q;
  logic [STAT_W-1:0] stat_d, stat_q;

  phy_pwr_fsm #(
    .HOLD_CYC(HOLD_CYC), .STEP_CYC(STEP_CYC), .TO_W(TO_W)
  ) pwr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .timeout_i(timeout_i),
    .lock_i(phy_lock_i), .clk_stop_i(clk_stop_i), .dat0_stop_i(dat_stop_i[0]),
    .en_clk_o(en_clk), .shut_n_o(shut_n), .rst_n_o(rst_n),
    .ready_o(ready), .fault_o(fault_o)
  );

  lane_stop_mask #(.LANES(LANES)) mask_i (
    .lane_cnt_i(lane_cnt_i), .stop_i(dat_stop_i), .all_stop_o(all_stop)
  );

  clk_lane_fsm #(.CLK_TW(CLK_TW), .DAT_TW(DAT_TW)) clk_i_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(ready), .auto_i(auto_clk_i),
    .hs_req_i(hs_clk_req_i), .tx_req_i(tx_req_i), .lanes_stopped_i(all_stop),
    .clk_lp2hs_i(clk_lp2hs_i), .clk_hs2lp_i(clk_hs2lp_i),
    .dat_lp2hs_i(dat_lp2hs_i), .dat_hs2lp_i(dat_hs2lp_i),
    .clk_hs_req_o(clk_hs_req_o), .tx_go_o(tx_go_o)
  );

  always_comb begin
    stat_d    = '0;
    stat_d[0] = phy_lock_i;
    stat_d[2] = clk_stop_i;
    for (int i = 0; i < LANES; i++) stat_d[lane_stat_bit(i)] = dat_stop_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      force_q <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      force_q <= force_pll_i;
    end
  end

  assign status_o   = stat_q;
  assign ready_o    = ready;
  assign phy_ctrl_o = {force_q, en_clk, rst_n, shut_n};
endmodule

// File: rtl/phy_link_seq_chk.sv
`timescale 1ns/1ps
module phy_link_seq_chk #(
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       phy_ctrl_o,
  input logic             clk_hs_req_o,
  input logic             tx_go_o,
  input logic             ready_o,
  input logic             fault_o,
  input logic             clk_stop_i,
  input logic [LANES-1:0] dat_stop_i
);
  assert_rst_after_shut_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_ctrl_o[1] |-> phy_ctrl_o[0]);
  assert_shut_after_clk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_ctrl_o[0] |-> phy_ctrl_o[2]);
  assert_fault_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);
  assert_fault_parked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (phy_ctrl_o[2:0] == 3'b000) && !ready_o);
  assert_ready_qual_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(clk_stop_i && dat_stop_i[0]));
  assert_ready_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> phy_ctrl_o[1]);
  assert_no_hs_early_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !clk_hs_req_o && !tx_go_o);
  assert_go_needs_clk_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_go_o |-> clk_hs_req_o);
endmodule

bind phy_link_seq phy_link_seq_chk #(.LANES(LANES)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .phy_ctrl_o(phy_ctrl_o),
  .clk_hs_req_o(clk_hs_req_o), .tx_go_o(tx_go_o), .ready_o(ready_o),
  .fault_o(fault_o), .clk_stop_i(clk_stop_i), .dat_stop_i(dat_stop_i)
);

// File: tb/phy_link_seq_tb_top.sv
`timescale 1ns/1ps
module phy_link_seq_tb_top;
  localparam int HOLD = 7;
  localparam int STEP = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, force_pll_i = 0, auto_clk_i = 0, hs_clk_req_i = 0, tx_req_i = 0;
  logic [1:0] lane_cnt_i = 2'd3;
  logic [15:0] timeout_i = 16'd200;
  logic [9:0] clk_lp2hs_i = 0, clk_hs2lp_i = 0;
  logic [7:0] dat_lp2hs_i = 0, dat_hs2lp_i = 0;
  logic phy_lock_i = 0, clk_stop_i = 0;
  logic [3:0] dat_stop_i = 0;
  logic [3:0] phy_ctrl_o;
  logic [11:0] status_o;
  logic clk_hs_req_o, tx_go_o, ready_o, fault_o;

  int checks = 0, fails = 0, n = 0, cyc = 0;
  int unsigned seed_s = 32'h5eed1234;

  always #2.5 clk = ~clk;

  phy_link_seq #(.HOLD_CYC(HOLD), .STEP_CYC(STEP)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .force_pll_i(force_pll_i),
    .auto_clk_i(auto_clk_i), .hs_clk_req_i(hs_clk_req_i), .tx_req_i(tx_req_i),
    .lane_cnt_i(lane_cnt_i), .timeout_i(timeout_i), .clk_lp2hs_i(clk_lp2hs_i),
    .clk_hs2lp_i(clk_hs2lp_i), .dat_lp2hs_i(dat_lp2hs_i), .dat_hs2lp_i(dat_hs2lp_i),
    .phy_lock_i(phy_lock_i), .clk_stop_i(clk_stop_i), .dat_stop_i(dat_stop_i),
    .phy_ctrl_o(phy_ctrl_o), .status_o(status_o), .clk_hs_req_o(clk_hs_req_o),
    .tx_go_o(tx_go_o), .ready_o(ready_o), .fault_o(fault_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic [11:0] exp_status(input logic lk, input logic cs, input logic [3:0] ds);
    logic [11:0] s = '0;
    s[0] = lk; s[2] = cs; s[4] = ds[0]; s[7] = ds[1]; s[9] = ds[2]; s[11] = ds[3];
    return s;
  endfunction

  task automatic do_reset();
    rst_ni = 0; start_i = 0; tx_req_i = 0; hs_clk_req_i = 0; auto_clk_i = 0;
    step(2);
    rst_ni = 1;
    step(1);
  endtask

  task automatic pulse_start();
    start_i = 1; step(1); start_i = 0;
  endtask

  // auto-mode burst: returns nothing, checks R8/R9 timings
  task automatic burst(input int l1, input int l2, input int d1, input int d2, input int hold);
    clk_lp2hs_i = 10'(l1); dat_lp2hs_i = 8'(l2);
    clk_hs2lp_i = 10'(d1); dat_hs2lp_i = 8'(d2);
    tx_req_i = 1; step(1);
    chk("R8 clk req rise", clk_hs_req_o, 1);
    n = 1;
    while (!tx_go_o && n < 200) begin step(1); n++; end
    chk("R8 go lead", n, l1 + l2 + 3);
    step(hold);
    tx_req_i = 0; step(1);
    chk("R9 go fall", tx_go_o, 0);
    n = 1;
    while (clk_hs_req_o && n < 200) begin step(1); n++; end
    chk("R9 clk tail", n, d1 + d2 + 4);
    step(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual %0d expected done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) cyc++;

  initial begin
    void'($urandom(seed_s));
    step(2);
    // R1 during and after reset
    chk("R1 ctrl in reset", phy_ctrl_o, 0);
    chk("R1 ready in reset", ready_o, 0);
    rst_ni = 1; step(1);
    chk("R1 ctrl", phy_ctrl_o, 0);
    chk("R1 outs", {clk_hs_req_o, tx_go_o, ready_o, fault_o}, 0);
    chk("R1 status", status_o, 0);

    // R2/R3 power-up ordering, R12 manual request before ready
    hs_clk_req_i = 1; tx_req_i = 1;
    start_i = 1; step(1); start_i = 0;
    n = 1;
    while (phy_ctrl_o[2] !== 1'b1 && n < 100) begin
      chk("R12 no hs before ready", {clk_hs_req_o, tx_go_o}, 0);
      step(1); n++;
    end
    chk("R2 hold length", n, HOLD + 2);
    chk("R3 later controls low", phy_ctrl_o[1:0], 0);
    pulse_start(); // R2: ignored mid-sequence
    n = 1;
    while (phy_ctrl_o[0] !== 1'b1 && n < 100) begin step(1); n++; end
    chk("R3 shutdown spacing", n, STEP + 1);
    n = 0;
    while (phy_ctrl_o[1] !== 1'b1 && n < 100) begin step(1); n++; end
    chk("R3 reset spacing", n, STEP + 1);
    tx_req_i = 0;

    // R4 qualification
    step(5);
    chk("R4 no ready without lock", ready_o, 0);
    phy_lock_i = 1; step(5);
    chk("R4 no ready without stop", ready_o, 0);
    clk_stop_i = 1; step(3);
    chk("R4 no ready without lane0", ready_o, 0);
    dat_stop_i = 4'b0001; step(1);
    chk("R4 ready with clk+lane0 only", ready_o, 1);
    pulse_start(); step(2);
    chk("R2 start ignored when ready", {phy_ctrl_o[2:0], ready_o}, 4'b1111);

    // R11 manual mode
    for (int i = 0; i < 20; i++) begin
      logic h, t;
      h = 1'($urandom); t = 1'($urandom);
      hs_clk_req_i = h; tx_req_i = t; step(1);
      chk("R11 manual clk", clk_hs_req_o, h);
      chk("R11 manual go", tx_go_o, h & t);
    end
    hs_clk_req_i = 0; tx_req_i = 0; step(1);

    // R7 force PLL
    force_pll_i = 1; step(1);
    chk("R7 force on", phy_ctrl_o[3], 1);
    force_pll_i = 0; step(1);
    chk("R7 force off", phy_ctrl_o[3], 0);

    // R6 status mapping
    for (int i = 0; i < 10; i++) begin
      logic lk, cs; logic [3:0] ds;
      lk = 1'($urandom); cs = 1'($urandom); ds = 4'($urandom);
      phy_lock_i = lk; clk_stop_i = cs; dat_stop_i = ds; step(1);
      chk("R6 status", status_o, exp_status(lk, cs, ds));
    end
    phy_lock_i = 1; clk_stop_i = 1; dat_stop_i = 4'hf;

    // R8/R9 automatic mode
    auto_clk_i = 1; hs_clk_req_i = 1; step(3);
    chk("R8 manual req ignored in auto", clk_hs_req_o, 0);
    hs_clk_req_i = 0;
    burst(0, 0, 0, 0, 1);
    for (int i = 0; i < 12; i++)
      burst(int'($urandom % 12), int'($urandom % 12), int'($urandom % 12),
            int'($urandom % 12), 1 + int'($urandom % 5));

    // R10 lane masking
    lane_cnt_i = 2'd3;
    clk_lp2hs_i = 2; dat_lp2hs_i = 1; clk_hs2lp_i = 4; dat_hs2lp_i = 3;
    tx_req_i = 1; step(12);
    dat_stop_i = 4'b0111;
    tx_req_i = 0; step(3 + 4 + 10);
    chk("R10 wait for lane3", clk_hs_req_o, 1);
    dat_stop_i = 4'hf; n = 0;
    while (clk_hs_req_o && n < 100) begin step(1); n++; end
    chk("R10 tail after stop", n, 4 + 2);
    step(2);
    lane_cnt_i = 2'd1; dat_stop_i = 4'b0011;
    burst(2, 1, 4, 3, 2);
    dat_stop_i = 4'hf; auto_clk_i = 0;

    // R5 lock timeout
    do_reset();
    timeout_i = 10; phy_lock_i = 0; clk_stop_i = 1; dat_stop_i = 4'hf;
    pulse_start(); n = 0;
    while (phy_ctrl_o[1] !== 1'b1 && n < 100) begin step(1); n++; end
    n = 0;
    while (!fault_o && n < 100) begin step(1); n++; end
    chk("R5 lock timeout", n, 11);
    chk("R5 parked", {phy_ctrl_o[2:0], ready_o}, 0);
    phy_lock_i = 1; pulse_start(); step(5);
    chk("R5 sticky", {fault_o, phy_ctrl_o[2:0]}, 4'b1000);

    // R5 stop timeout
    do_reset();
    timeout_i = 6; phy_lock_i = 1; clk_stop_i = 0; dat_stop_i = 0;
    pulse_start(); n = 0;
    while (phy_ctrl_o[1] !== 1'b1 && n < 100) begin step(1); n++; end
    n = 0;
    while (!fault_o && n < 100) begin step(1); n++; end
    chk("R5 stop timeout", n, 8);
    chk("R5 no ready", ready_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule